// File: doc/BRIEF.md
# Directory-Based Remote Probe Filter

This block is the coherence directory of a node-interconnect bridge. It remembers which lines of local memory are now cached by other nodes, the MOSI state of each such line, and an 8-bit vector of the nodes that hold it. When the local memory controller broadcasts a probe, the block looks up the line. It then returns the set of remote nodes that must see the probe. That set is empty or it is the line's sharer vector, so link bandwidth and latency are spent only where a copy exists.

The same request port also carries traffic from remote nodes: read fetches, read-for-modify fetches and eviction notices. These update the entries. The directory has a fixed number of fully associative entries. When a new line arrives and no entry is free, the block reclaims one entry in round-robin order and first emits an invalidating probe to every holder of the line being dropped.

Requests enter on a valid/ready port and remote-probe decisions leave on a valid/ready port. The block keeps at most one decision in flight. `req_ready` is low while a decision waits on the output, and that decision's fields are held unchanged until `prb_ready` takes it.

Top module: `pfilt_top`

## Requirements
- R1: After reset the directory holds no lines, `prb_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while `prb_valid` is 1. A request offered during that time is not taken and has no effect. While `prb_valid` is 1 and `prb_ready` is 0, `prb_mask`, `prb_addr` and `prb_inval` hold their values.
- R3: Each accepted local probe (`req_kind` 0 = read-shared, 1 = invalidating) produces exactly one output with `prb_valid` high in the next cycle, with `prb_addr` equal to the request address. On a directory miss, `prb_mask` is all zeros.
- R4: A read-shared probe sets `prb_inval` to 0. For a line in Shared state it gives an empty mask. For a line in Modified or Owned state it gives the single owning node's bit.
- R5: An invalidating probe that hits gives `prb_mask` equal to the full sharer vector with `prb_inval` = 1, and it frees the entry.
- R6: A remote read (`req_kind` 2) from node n sets bit n of the line's vector (bit n of `prb_mask` stands for node n) and puts the line in Shared state. It allocates an entry on a miss. It produces no output unless an entry must be reclaimed.
- R7: A remote read-for-modify (`req_kind` 3) from node n leaves bit n as the only sharer and puts the line in Modified state.
- R8: An eviction notice (`req_kind` 4) from node n clears bit n. When the vector becomes zero the entry is freed. A notice for a line not present has no effect, and no output is produced.
- R9: Remote requests whose source `req_node` equals the local node number are ignored, so the local node's bit never appears in `prb_mask`.
- R10: A remote fetch that misses when every entry is in use reclaims entries in round-robin order starting at entry 0. Free entries are filled lowest index first. The block emits `prb_inval` = 1 with the victim's address and full sharer vector, and installs the new line in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_kind | input | 3 | 0 read-shared probe, 1 invalidating probe, 2 remote read, 3 remote read-for-modify, 4 eviction notice |
| req_addr | input | 16 | Line address |
| req_node | input | 3 | Source node of a remote request |
| prb_valid | output | 1 | Remote probe decision present |
| prb_ready | input | 1 | Consumer takes the decision |
| prb_addr | output | 16 | Line the decision applies to |
| prb_mask | output | 8 | Remote nodes to probe, bit n = node n |
| prb_inval | output | 1 | Probe invalidates the remote copies |

## Verification
The checker assumes that `req_kind` takes only the five defined codes. It also assumes that the owner of a Modified line is recorded only through read-for-modify, so a non-invalidating decision never carries more than one node bit. The directed stimulus uses only these codes. It drives requests and `prb_ready` on the falling edge, and it offers a request during back-pressure only to show that the request is refused. Some remote requests use the local node number as their source, but the bench then confirms through later probes that such requests left no trace.

// File: rtl/pfilt_pkg.sv
package pfilt_pkg;
  typedef enum logic [2:0] {
    K_PRB_SHARED = 3'd0,
    K_PRB_INVAL  = 3'd1,
    K_RMT_READ   = 3'd2,
    K_RMT_RFM    = 3'd3,
    K_RMT_EVICT  = 3'd4
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_O = 2'd2,
    ST_M = 2'd3
  } mosi_e;
endpackage

// File: rtl/pfilt_match.sv
module pfilt_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]             ent_v,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag,
  input  logic [ADDR_W-1:0]              addr,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx,
  output logic                           has_free,
  output logic [IDX_W-1:0]               free_idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = ent_v[g] && (ent_tag[g] == addr);
  end

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!ent_v[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pfilt_victim.sv
module pfilt_victim #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/pfilt_top.sv
module pfilt_top
  import pfilt_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int ADDR_W   = 16,
  parameter int NODES    = 8,
  parameter int LOCAL_ID = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [2:0]                req_kind,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [$clog2(NODES)-1:0]  req_node,
  output logic                      prb_valid,
  input  logic                      prb_ready,
  output logic [ADDR_W-1:0]         prb_addr,
  output logic [NODES-1:0]          prb_mask,
  output logic                      prb_inval
);
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int NODE_W = $clog2(NODES);

  logic [ENTRIES-1:0]             ent_v;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
  logic [ENTRIES-1:0][NODES-1:0]  ent_sh;
  mosi_e                          ent_st [ENTRIES];

  logic             hit, has_free, victim_adv;
  logic [IDX_W-1:0] hit_idx, free_idx, victim_ptr, fill_idx;
  logic             acc, from_local, is_fetch;
  logic [NODES-1:0] node_bit, hit_sh;
  mosi_e            hit_st;
  req_kind_e        kind;

  pfilt_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .ent_v(ent_v), .ent_tag(ent_tag), .addr(req_addr),
    .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
  );

  pfilt_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .adv(victim_adv), .ptr(victim_ptr)
  );

  assign req_ready  = !prb_valid;
  assign acc        = req_valid && req_ready;
  assign kind       = req_kind_e'(req_kind);
  assign from_local = (req_node == NODE_W'(LOCAL_ID));
  assign node_bit   = NODES'(1) << req_node;
  assign hit_sh     = ent_sh[hit_idx];
  assign hit_st     = ent_st[hit_idx];
  assign is_fetch   = (kind == K_RMT_READ) || (kind == K_RMT_RFM);
  assign fill_idx   = has_free ? free_idx : victim_ptr;
  assign victim_adv = acc && is_fetch && !from_local && !hit && !has_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v     <= '0;
      prb_valid <= 1'b0;
      prb_addr  <= '0;
      prb_mask  <= '0;
      prb_inval <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_tag[i] <= '0;
        ent_sh[i]  <= '0;
        ent_st[i]  <= ST_I;
      end
    end else begin
      if (prb_valid && prb_ready) prb_valid <= 1'b0;
      if (acc) begin
        case (kind)
          K_PRB_SHARED: begin
            prb_valid <= 1'b1;
            prb_addr  <= req_addr;
            prb_inval <= 1'b0;
            prb_mask  <= (hit && (hit_st == ST_M || hit_st == ST_O)) ? hit_sh : '0;
          end
          K_PRB_INVAL: begin
            prb_valid <= 1'b1;
            prb_addr  <= req_addr;
            prb_inval <= 1'b1;
            prb_mask  <= hit ? hit_sh : '0;
            if (hit) begin
              ent_v[hit_idx]  <= 1'b0;
              ent_sh[hit_idx] <= '0;
              ent_st[hit_idx] <= ST_I;
            end
          end
          K_RMT_READ, K_RMT_RFM: begin
            if (!from_local) begin
              if (hit) begin
                ent_sh[hit_idx] <= (kind == K_RMT_READ) ? (hit_sh | node_bit) : node_bit;
                ent_st[hit_idx] <= (kind == K_RMT_READ) ? ST_S : ST_M;
              end else begin
                if (!has_free) begin
                  prb_valid <= 1'b1;
                  prb_addr  <= ent_tag[victim_ptr];
                  prb_mask  <= ent_sh[victim_ptr];
                  prb_inval <= 1'b1;
                end
                ent_v[fill_idx]   <= 1'b1;
                ent_tag[fill_idx] <= req_addr;
                ent_sh[fill_idx]  <= node_bit;
                ent_st[fill_idx]  <= (kind == K_RMT_READ) ? ST_S : ST_M;
              end
            end
          end
          K_RMT_EVICT: begin
            if (!from_local && hit) begin
              ent_sh[hit_idx] <= hit_sh & ~node_bit;
              if ((hit_sh & ~node_bit) == '0) begin
                ent_v[hit_idx]  <= 1'b0;
                ent_st[hit_idx] <= ST_I;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pfilt_top_chk.sv
module pfilt_top_chk #(
  parameter int ADDR_W   = 16,
  parameter int NODES    = 8,
  parameter int LOCAL_ID = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_kind,
  input logic              prb_valid,
  input logic              prb_ready,
  input logic [ADDR_W-1:0] prb_addr,
  input logic [NODES-1:0]  prb_mask,
  input logic              prb_inval
);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    prb_valid && !prb_ready |=> prb_valid && $stable(prb_mask) && $stable(prb_addr) && $stable(prb_inval));

  a_r2_no_accept: assert property (@(posedge clk) disable iff (rst)
    prb_valid |-> !req_ready);

  a_r3_probe_reply: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_kind <= 3'd1) |=> prb_valid);

  a_r9_local_bit: assert property (@(posedge clk) disable iff (rst)
    prb_valid |-> !prb_mask[LOCAL_ID]);

  a_r4_single_owner: assert property (@(posedge clk) disable iff (rst)
    prb_valid && !prb_inval |-> $countones(prb_mask) <= 1);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !prb_valid && req_ready);
endmodule

bind pfilt_top pfilt_top_chk #(.ADDR_W(ADDR_W), .NODES(NODES), .LOCAL_ID(LOCAL_ID)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .prb_valid(prb_valid), .prb_ready(prb_ready),
  .prb_addr(prb_addr), .prb_mask(prb_mask), .prb_inval(prb_inval)
);

// File: tb/pfilt_top_test.sv
module pfilt_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_node = '0;
  logic        prb_valid;
  logic        prb_ready = 1'b0;
  logic [15:0] prb_addr;
  logic [7:0]  prb_mask;
  logic        prb_inval;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pfilt_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_node(req_node),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_addr(prb_addr),
    .prb_mask(prb_mask), .prb_inval(prb_inval)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [15:0] a, input logic [2:0] n);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_node = n;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_probe(input string req, input logic [15:0] a, input logic [7:0] m, input logic inv);
    @(negedge clk);
    check({req, " valid"}, 32'(prb_valid), 32'd1);
    check({req, " addr"},  32'(prb_addr),  32'(a));
    check({req, " mask"},  32'(prb_mask),  32'(m));
    check({req, " inval"}, 32'(prb_inval), 32'(inv));
    prb_ready = 1'b1;
    @(posedge clk); #1;
    prb_ready = 1'b0;
  endtask

  task automatic expect_none(input string req);
    @(negedge clk);
    check({req, " no output"}, 32'(prb_valid), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 prb_valid", 32'(prb_valid), 32'd0);
    check("R1 req_ready", 32'(req_ready), 32'd1);
    send(3'd1, 16'h0010, 3'd0);
    expect_probe("R1 R3 miss after reset", 16'h0010, 8'h00, 1'b1);
  endtask

  task automatic t_shared();
    send(3'd2, 16'h0010, 3'd2); expect_none("R6 read n2");
    send(3'd2, 16'h0010, 3'd5); expect_none("R6 read n5");
    send(3'd0, 16'h0010, 3'd0); expect_probe("R4 R6 shared line", 16'h0010, 8'h00, 1'b0);
    send(3'd1, 16'h0010, 3'd0); expect_probe("R5 R6 inval sharers", 16'h0010, 8'h24, 1'b1);
    send(3'd1, 16'h0010, 3'd0); expect_probe("R5 freed", 16'h0010, 8'h00, 1'b1);
  endtask

  task automatic t_rfm();
    send(3'd2, 16'h0020, 3'd1); expect_none("R6 read n1");
    send(3'd3, 16'h0020, 3'd6); expect_none("R7 rfm n6");
    send(3'd0, 16'h0020, 3'd0); expect_probe("R4 R7 owner only", 16'h0020, 8'h40, 1'b0);
    send(3'd1, 16'h0020, 3'd0); expect_probe("R7 single sharer", 16'h0020, 8'h40, 1'b1);
  endtask

  task automatic t_evict();
    send(3'd2, 16'h0030, 3'd3); send(3'd2, 16'h0030, 3'd4);
    send(3'd4, 16'h0030, 3'd7); expect_none("R8 notice from non-sharer");
    send(3'd4, 16'h0030, 3'd3); expect_none("R8 notice n3");
    send(3'd4, 16'h0099, 3'd3); expect_none("R8 notice on miss");
    send(3'd1, 16'h0030, 3'd0); expect_probe("R8 bit cleared", 16'h0030, 8'h10, 1'b1);
    send(3'd2, 16'h0031, 3'd3);
    send(3'd4, 16'h0031, 3'd3);
    send(3'd1, 16'h0031, 3'd0); expect_probe("R8 entry freed", 16'h0031, 8'h00, 1'b1);
  endtask

  task automatic t_local();
    send(3'd2, 16'h0040, 3'd0); expect_none("R9 local read");
    send(3'd1, 16'h0040, 3'd0); expect_probe("R9 local read ignored", 16'h0040, 8'h00, 1'b1);
    send(3'd2, 16'h0041, 3'd2);
    send(3'd3, 16'h0041, 3'd0);
    send(3'd4, 16'h0041, 3'd0);
    send(3'd1, 16'h0041, 3'd0); expect_probe("R9 local rfm/evict ignored", 16'h0041, 8'h04, 1'b1);
  endtask

  task automatic t_backpressure();
    send(3'd0, 16'h0050, 3'd0);
    @(negedge clk);
    check("R2 req_ready low", 32'(req_ready), 32'd0);
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h0051; req_node = 3'd2;
    @(negedge clk);
    @(negedge clk);
    check("R2 still pending", 32'(prb_valid), 32'd1);
    check("R2 mask held", 32'(prb_mask), 32'd0);
    check("R2 addr held", 32'(prb_addr), 32'h0050);
    req_valid = 1'b0;
    expect_probe("R2 R3 miss", 16'h0050, 8'h00, 1'b0);
    send(3'd1, 16'h0051, 3'd0); expect_probe("R2 refused req no effect", 16'h0051, 8'h00, 1'b1);
  endtask

  task automatic t_capacity();
    for (int i = 0; i < 4; i++) begin
      send(3'd2, 16'h0060 + 16'(i), 3'd2);
      expect_none("R10 fill");
    end
    send(3'd2, 16'h0064, 3'd3); expect_probe("R10 victim 0", 16'h0060, 8'h04, 1'b1);
    send(3'd3, 16'h0065, 3'd5); expect_probe("R10 victim 1", 16'h0061, 8'h04, 1'b1);
    send(3'd1, 16'h0064, 3'd0); expect_probe("R10 new line installed", 16'h0064, 8'h08, 1'b1);
    send(3'd1, 16'h0060, 3'd0); expect_probe("R10 victim dropped", 16'h0060, 8'h00, 1'b1);
    send(3'd0, 16'h0065, 3'd0); expect_probe("R10 R7 rfm fill owner", 16'h0065, 8'h20, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_shared();
    t_rfm();
    t_evict();
    t_local();
    t_backpressure();
    t_capacity();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule